// File: doc/BRIEF.md
# Binary Fully Connected Unit

This unit executes one custom processor instruction that scores a binarised fully connected neuron. A 5×5 matrix of 1-bit activations and a matching 5×5 matrix of 1-bit weights each arrive as a 40-bit vector of five bytes. Every byte carries one matrix row in its five low bits. The unit takes the bitwise equivalence (XNOR) of the two vectors, counts the ones, and writes that count to the destination register one cycle later.

The padding rule is what makes the count correct. Activation bytes fill their three high bits with zeros and weight bytes fill theirs with ones, so each padded position compares unequal and adds nothing to the count. A plain count over all 40 bits therefore equals the neuron's dot-product count, which is at most 25.

Layers with more than 25 inputs are split across several calls. An accumulate flag adds each new count to a running sum inside the unit. A clear flag zeroes that sum before the current call is applied. The software picks the winning class itself; this unit does not.

Top module: `bnn_fc_unit`

## Requirements
- R1: A command is taken only when `cmd_valid` is 1, `cmd_opcode` is 7'b1111011, `cmd_funct3` is 3'b101 and `cmd_funct7` is 7'b0000000. Any other command produces no `rsp_valid` and leaves the running sum unchanged.
- R2: A command that is taken at a clock edge makes `rsp_valid` 1 for the cycle that follows. When no command is taken, `rsp_valid` is 0 in the next cycle.
- R3: The count is the number of ones in the bitwise XNOR of `act_vec` and `wgt_vec` over all 40 bits, with byte k at bits [8k+7:8k]. Pad bits are counted like any other bit.
- R4: When every activation byte has 3'b000 in bits [7:5] and every weight byte has 3'b111 there, the count equals the number of the 25 row positions at which activation and weight agree, and it never exceeds 25.
- R5: `rsp_data` is the result zero-extended to 32 bits.
- R6: With `cmd_acc` set to 1, the count is added to the running sum, and the updated sum is returned and kept.
- R7: With `cmd_clr` set to 1, the running sum is taken as zero before this command is applied. With `cmd_acc` set to 0, this leaves the sum at zero and returns the count.
- R8: After reset, `rsp_valid` is 0, `rsp_data` is 0 and the running sum is 0.
- R9: A command taken with `cmd_acc` and `cmd_clr` both 0 returns the bare count and leaves the running sum unchanged.
- R10: `rsp_data` holds its last value through every cycle in which `rsp_valid` is 0.
- R11: Commands on consecutive cycles are each answered in turn, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present |
| cmd_opcode | input | 7 | Major opcode of the instruction |
| cmd_funct3 | input | 3 | funct3 field of the instruction |
| cmd_funct7 | input | 7 | funct7 field of the instruction |
| cmd_acc | input | 1 | Add the count to the running sum |
| cmd_clr | input | 1 | Zero the running sum before this command |
| act_vec | input | 40 | Five activation bytes, one row in the low 5 bits of each |
| wgt_vec | input | 40 | Five weight bytes, packed the same way |
| rsp_valid | output | 1 | Result pulse, one cycle after a command is taken |
| rsp_data | output | 32 | Zero-extended result |

## Verification
Each property assumes that a command is either decoded completely or ignored, and that the operand vectors are stable at the clock edge on which the command is taken. The upper bound on the count is checked only on calls that do not accumulate and that follow the padding rule (activation pads zero, weight pads one). The stimulus table keeps to that rule in every row. One directed test breaks it on purpose (all pad bits set to one) to show that pad bits are counted when the rule is not followed; on that call the bound property is inactive, because its guard on the padding rule is false. Accumulated sums grow above 25 by design, so the bound is never applied to accumulating calls.

// File: rtl/bnn_fc_pkg.sv
package bnn_fc_pkg;

   // Instruction encoding that selects this unit
   localparam logic [6:0] FC_OPCODE = 7'b1111011;
   localparam logic [2:0] FC_FUNCT3 = 3'b101;
   localparam logic [6:0] FC_FUNCT7 = 7'b0000000;

   // Popcount structure variants
   localparam int POP_LANE_TREE = 0;
   localparam int POP_FLAT      = 1;

   typedef struct packed {
      logic valid;
      logic [6:0] opcode;
      logic [2:0] funct3;
      logic [6:0] funct7;
   } fc_cmd_t;

endpackage

// File: rtl/bnn_fc_decode.sv
module bnn_fc_decode
   import bnn_fc_pkg::*;
(
   input  fc_cmd_t cmd,
   output logic    hit
);

   logic op_ok;
   logic f3_ok;
   logic f7_ok;

   always_comb begin
      op_ok = (cmd.opcode == FC_OPCODE);
      f3_ok = (cmd.funct3 == FC_FUNCT3);
      f7_ok = (cmd.funct7 == FC_FUNCT7);
      hit   = cmd.valid & op_ok & f3_ok & f7_ok;
   end

endmodule

// File: rtl/bnn_fc_xnor.sv
module bnn_fc_xnor #(
   parameter int LANES  = 5,
   parameter int LANE_W = 8,
   localparam int VEC_W = LANES * LANE_W
) (
   input  logic [VEC_W-1:0] act,
   input  logic [VEC_W-1:0] wgt,
   output logic [VEC_W-1:0] agree
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign agree[k*LANE_W +: LANE_W] = ~(act[k*LANE_W +: LANE_W] ^ wgt[k*LANE_W +: LANE_W]);
   end

endmodule

// File: rtl/bnn_fc_popcnt.sv
module bnn_fc_popcnt
   import bnn_fc_pkg::*;
#(
   parameter int LANES     = 5,
   parameter int LANE_W    = 8,
   parameter int POP_STYLE = POP_LANE_TREE,
   localparam int VEC_W    = LANES * LANE_W,
   localparam int CNT_W    = $clog2(VEC_W + 1),
   localparam int LCNT_W   = $clog2(LANE_W + 1)
) (
   input  logic [VEC_W-1:0] bits,
   output logic [CNT_W-1:0] count
);

   if (POP_STYLE == POP_LANE_TREE) begin : g_tree
      logic [LCNT_W-1:0] lane_cnt [LANES];

      for (genvar k = 0; k < LANES; k++) begin : g_lane
         always_comb begin
            lane_cnt[k] = '0;
            for (int b = 0; b < LANE_W; b++) begin
               lane_cnt[k] = lane_cnt[k] + LCNT_W'(bits[k*LANE_W + b]);
            end
         end
      end

      always_comb begin
         count = '0;
         for (int k = 0; k < LANES; k++) begin
            count = count + CNT_W'(lane_cnt[k]);
         end
      end
   end else begin : g_flat
      always_comb begin
         count = '0;
         for (int i = 0; i < VEC_W; i++) begin
            count = count + CNT_W'(bits[i]);
         end
      end
   end

endmodule

// File: rtl/bnn_fc_accum.sv
module bnn_fc_accum #(
   parameter int CNT_W = 6,
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             acc,
   input  logic             clr,
   input  logic [CNT_W-1:0] count,
   output logic [ACC_W-1:0] result,
   output logic [ACC_W-1:0] sum_q
);

   logic [ACC_W-1:0] base;
   logic [ACC_W-1:0] total;
   logic [ACC_W-1:0] sum_d;

   always_comb begin
      base   = clr ? '0 : sum_q;
      total  = base + ACC_W'(count);
      result = acc ? total : ACC_W'(count);
      if (!hit) begin
         sum_d = sum_q;
      end else if (acc) begin
         sum_d = total;
      end else begin
         sum_d = base;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else begin
         sum_q <= sum_d;
      end
   end

endmodule

// File: rtl/bnn_fc_unit.sv
module bnn_fc_unit
   import bnn_fc_pkg::*;
#(
   parameter int ROWS      = 5,
   parameter int COLS      = 5,
   parameter int LANE_W    = 8,
   parameter int XLEN      = 32,
   parameter int ACC_W     = 16,
   parameter int POP_STYLE = POP_LANE_TREE,
   localparam int VEC_W    = ROWS * LANE_W,
   localparam int CNT_W    = $clog2(VEC_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [6:0]       cmd_opcode,
   input  logic [2:0]       cmd_funct3,
   input  logic [6:0]       cmd_funct7,
   input  logic             cmd_acc,
   input  logic             cmd_clr,
   input  logic [VEC_W-1:0] act_vec,
   input  logic [VEC_W-1:0] wgt_vec,
   output logic             rsp_valid,
   output logic [XLEN-1:0]  rsp_data
);

   if (COLS > LANE_W) begin : g_bad_cols
      $error("bnn_fc_unit: COLS must fit inside one lane");
   end
   if (ACC_W < CNT_W) begin : g_bad_acc
      $error("bnn_fc_unit: ACC_W narrower than the count");
   end
   if (XLEN < ACC_W) begin : g_bad_xlen
      $error("bnn_fc_unit: ACC_W wider than the result register");
   end
   if (POP_STYLE != POP_LANE_TREE && POP_STYLE != POP_FLAT) begin : g_bad_style
      $error("bnn_fc_unit: unknown POP_STYLE");
   end

   fc_cmd_t          cmd;
   logic             hit;
   logic [VEC_W-1:0] agree;
   logic [CNT_W-1:0] count;
   logic [ACC_W-1:0] result;
   logic [ACC_W-1:0] acc_sum;
   logic             rsp_valid_q;
   logic [XLEN-1:0]  rsp_data_q;

   assign cmd = '{valid: cmd_valid, opcode: cmd_opcode, funct3: cmd_funct3, funct7: cmd_funct7};

   bnn_fc_decode u_dec (
      .cmd (cmd),
      .hit (hit)
   );

   bnn_fc_xnor #(
      .LANES  (ROWS),
      .LANE_W (LANE_W)
   ) u_xnor (
      .act   (act_vec),
      .wgt   (wgt_vec),
      .agree (agree)
   );

   bnn_fc_popcnt #(
      .LANES     (ROWS),
      .LANE_W    (LANE_W),
      .POP_STYLE (POP_STYLE)
   ) u_pop (
      .bits  (agree),
      .count (count)
   );

   bnn_fc_accum #(
      .CNT_W (CNT_W),
      .ACC_W (ACC_W)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hit),
      .acc    (cmd_acc),
      .clr    (cmd_clr),
      .count  (count),
      .result (result),
      .sum_q  (acc_sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= hit;
         if (hit) begin
            rsp_data_q <= XLEN'(result);
         end
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/bnn_fc_unit_chk.sv
module bnn_fc_unit_chk
   import bnn_fc_pkg::*;
#(
   parameter int ROWS   = 5,
   parameter int COLS   = 5,
   parameter int LANE_W = 8,
   parameter int XLEN   = 32,
   parameter int ACC_W  = 16,
   localparam int VEC_W = ROWS * LANE_W,
   localparam int CNT_W = $clog2(VEC_W + 1),
   localparam int MAX_CNT = ROWS * COLS
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [6:0]       cmd_opcode,
   input logic [2:0]       cmd_funct3,
   input logic [6:0]       cmd_funct7,
   input logic             cmd_acc,
   input logic             cmd_clr,
   input logic [VEC_W-1:0] act_vec,
   input logic [VEC_W-1:0] wgt_vec,
   input logic             rsp_valid,
   input logic [XLEN-1:0]  rsp_data,
   input logic [ACC_W-1:0] sum_q
);

   function automatic logic [VEC_W-1:0] pad_mask();
      logic [VEC_W-1:0] m;
      for (int i = 0; i < VEC_W; i++) begin
         m[i] = ((i % LANE_W) >= COLS);
      end
      return m;
   endfunction

   localparam logic [VEC_W-1:0] PAD_MASK = pad_mask();

   logic taken;
   logic pad_ok;

   always_comb begin
      taken  = cmd_valid && cmd_opcode == FC_OPCODE && cmd_funct3 == FC_FUNCT3
               && cmd_funct7 == FC_FUNCT7;
      pad_ok = ((act_vec & PAD_MASK) == '0) && ((wgt_vec & PAD_MASK) == PAD_MASK);
   end

   a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> rsp_valid);

   a_r1_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |=> !rsp_valid);

   a_r1_sum_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |=> $stable(sum_q));

   a_r9_plain_keeps_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !cmd_acc && !cmd_clr) |=> $stable(sum_q));

   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !cmd_acc && pad_ok) |=> (rsp_data <= XLEN'(MAX_CNT)));

   a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !cmd_acc) |=> (rsp_data[XLEN-1:CNT_W] == '0));

   a_r7_clear_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && cmd_clr && !cmd_acc) |=> (sum_q == '0));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> $stable(rsp_data));

endmodule

bind bnn_fc_unit bnn_fc_unit_chk #(
   .ROWS   (ROWS),
   .COLS   (COLS),
   .LANE_W (LANE_W),
   .XLEN   (XLEN),
   .ACC_W  (ACC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_opcode (cmd_opcode),
   .cmd_funct3 (cmd_funct3),
   .cmd_funct7 (cmd_funct7),
   .cmd_acc    (cmd_acc),
   .cmd_clr    (cmd_clr),
   .act_vec    (act_vec),
   .wgt_vec    (wgt_vec),
   .rsp_valid  (rsp_valid),
   .rsp_data   (rsp_data),
   .sum_q      (acc_sum)
);

// File: tb/bnn_fc_unit_test.sv
module bnn_fc_unit_test;

   localparam logic [6:0] OPC = 7'b1111011;
   localparam logic [2:0] F3  = 3'b101;
   localparam logic [6:0] F7  = 7'b0000000;

   typedef struct packed {
      logic [39:0] act;
      logic [39:0] wgt;
      logic        acc;
      logic        clr;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   // req column: requirement number exercised by the row
   localparam int NVEC = 14;
   localparam vec_t TBL [NVEC] = '{
      '{ {5{8'h00}}, {5{8'hFF}}, 1'b0, 1'b0, 32'd0,  8'd4 },
      '{ {5{8'h1F}}, {5{8'hFF}}, 1'b0, 1'b0, 32'd25, 8'd4 },
      '{ {5{8'h00}}, {5{8'hE0}}, 1'b0, 1'b0, 32'd25, 8'd4 },
      '{ {5{8'h1F}}, {5{8'hE0}}, 1'b0, 1'b0, 32'd0,  8'd3 },
      '{ {8'h10, 8'h08, 8'h04, 8'h02, 8'h01}, {8'hF0, 8'hE8, 8'hE4, 8'hE2, 8'hE1},
         1'b0, 1'b0, 32'd25, 8'd3 },
      '{ {5{8'h15}}, {5{8'hE0}}, 1'b0, 1'b0, 32'd10, 8'd3 },
      '{ {5{8'h15}}, {5{8'hE0}}, 1'b1, 1'b1, 32'd10, 8'd7 },
      '{ {5{8'h1F}}, {5{8'hFF}}, 1'b1, 1'b0, 32'd35, 8'd6 },
      '{ {8'h10, 8'h08, 8'h04, 8'h02, 8'h01}, {8'hF0, 8'hE8, 8'hE4, 8'hE2, 8'hE1},
         1'b1, 1'b0, 32'd60, 8'd6 },
      '{ {5{8'h03}}, {5{8'hFF}}, 1'b0, 1'b0, 32'd10, 8'd9 },
      '{ {5{8'h00}}, {5{8'hFF}}, 1'b1, 1'b0, 32'd60, 8'd9 },
      '{ {5{8'h1F}}, {5{8'hFF}}, 1'b0, 1'b1, 32'd25, 8'd7 },
      '{ {5{8'h1F}}, {5{8'hFF}}, 1'b1, 1'b0, 32'd25, 8'd7 },
      '{ {8'h00, 8'h1F, 8'h00, 8'h1F, 8'h00}, {8'hFF, 8'hFF, 8'hE0, 8'hE0, 8'hFF},
         1'b0, 1'b0, 32'd10, 8'd5 }
   };

   logic        clk;
   logic        rst_n;
   logic        cmd_valid;
   logic [6:0]  cmd_opcode;
   logic [2:0]  cmd_funct3;
   logic [6:0]  cmd_funct7;
   logic        cmd_acc;
   logic        cmd_clr;
   logic [39:0] act_vec;
   logic [39:0] wgt_vec;
   logic        rsp_valid;
   logic [31:0] rsp_data;

   int n_chk;
   int n_fail;
   bit done;

   bnn_fc_unit uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_opcode (cmd_opcode),
      .cmd_funct3 (cmd_funct3),
      .cmd_funct7 (cmd_funct7),
      .cmd_acc    (cmd_acc),
      .cmd_clr    (cmd_clr),
      .act_vec    (act_vec),
      .wgt_vec    (wgt_vec),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [6:0] op, input logic [2:0] f3,
                        input logic [6:0] f7, input logic acc, input logic clr,
                        input logic [39:0] a, input logic [39:0] w);
      cmd_valid  = v;
      cmd_opcode = op;
      cmd_funct3 = f3;
      cmd_funct7 = f7;
      cmd_acc    = acc;
      cmd_clr    = clr;
      act_vec    = a;
      wgt_vec    = w;
   endtask

   task automatic idle();
      drive(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0);
   endtask

   // Presents one command for one cycle; returns at the negedge after the capturing edge
   task automatic issue(input logic [6:0] op, input logic [2:0] f3, input logic [6:0] f7,
                        input logic acc, input logic clr,
                        input logic [39:0] a, input logic [39:0] w);
      @(negedge clk);
      drive(1'b1, op, f3, f7, acc, clr, a, w);
      @(negedge clk);
      idle();
   endtask

   initial begin
      int wd;
      for (wd = 0; wd < 100000 && !done; wd++) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      n_chk  = 0;
      n_fail = 0;
      done   = 1'b0;
      rst_n  = 1'b0;
      idle();
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      check("R8 rsp_data in reset", rsp_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: sum starts at zero, seen through an accumulating call of count 0
      issue(OPC, F3, F7, 1'b1, 1'b0, {5{8'h00}}, {5{8'hFF}});
      check("R8 sum after reset", rsp_data, 32'd0);

      // Table walk: R3 R4 R5 R6 R7 R9 and R2 on each row
      for (int i = 0; i < NVEC; i++) begin
         issue(OPC, F3, F7, TBL[i].acc, TBL[i].clr, TBL[i].act, TBL[i].wgt);
         check($sformatf("R2 valid row %0d", i), {31'd0, rsp_valid}, 32'd1);
         check($sformatf("R%0d data row %0d", TBL[i].req, i), rsp_data, TBL[i].exp);
      end
      // sum is now 25 (row 12)

      // R2: pulse lasts a single cycle
      @(negedge clk);
      check("R2 pulse ends", {31'd0, rsp_valid}, 32'd0);
      // R10: data held while idle
      check("R10 data held", rsp_data, 32'd10);

      // R1: wrong funct3, funct7, opcode, and valid low are all ignored
      held = rsp_data;
      issue(OPC, 3'b100, F7, 1'b1, 1'b1, {5{8'h1F}}, {5{8'hFF}});
      check("R1 funct3 mismatch valid", {31'd0, rsp_valid}, 32'd0);
      check("R1 funct3 mismatch data", rsp_data, held);
      issue(OPC, F3, 7'b0000001, 1'b1, 1'b1, {5{8'h1F}}, {5{8'hFF}});
      check("R1 funct7 mismatch valid", {31'd0, rsp_valid}, 32'd0);
      issue(7'b0110011, F3, F7, 1'b1, 1'b1, {5{8'h1F}}, {5{8'hFF}});
      check("R1 opcode mismatch valid", {31'd0, rsp_valid}, 32'd0);
      @(negedge clk);
      drive(1'b0, OPC, F3, F7, 1'b1, 1'b1, {5{8'h1F}}, {5{8'hFF}});
      @(negedge clk);
      idle();
      check("R1 valid low ignored", {31'd0, rsp_valid}, 32'd0);
      // R1: sum still 25 after all ignored commands
      issue(OPC, F3, F7, 1'b1, 1'b0, {5{8'h00}}, {5{8'hFF}});
      check("R1 sum unchanged", rsp_data, 32'd25);

      // R3: pad rule broken, all 40 bits agree
      issue(OPC, F3, F7, 1'b0, 1'b0, {5{8'hFF}}, {5{8'hFF}});
      check("R3 pad bits counted", rsp_data, 32'd40);

      // R11: back-to-back commands
      @(negedge clk);
      drive(1'b1, OPC, F3, F7, 1'b0, 1'b1, {5{8'h15}}, {5{8'hE0}});
      @(negedge clk);
      check("R11 first valid", {31'd0, rsp_valid}, 32'd1);
      check("R11 first data", rsp_data, 32'd10);
      drive(1'b1, OPC, F3, F7, 1'b1, 1'b0, {5{8'h1F}}, {5{8'hFF}});
      @(negedge clk);
      idle();
      check("R11 second valid", {31'd0, rsp_valid}, 32'd1);
      check("R6 second data", rsp_data, 32'd25);

      // R6: sum grows past the single-call bound and stays zero-extended (R5)
      for (int k = 0; k < 4; k++) begin
         issue(OPC, F3, F7, 1'b1, 1'b0, {5{8'h1F}}, {5{8'hFF}});
      end
      check("R6 sum after five calls", rsp_data, 32'd125);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule